// File: doc/BRIEF.md
# Hardware LIFO Stack Unit

This block is the complete data store of a zero-address processor. The CPU talks to it over one bidirectional data bus and a few strobes. A push stores the word the CPU places on the bus as the new top of stack. A pop puts the top word on the bus during the same cycle and removes it at the clock edge. A peek shows the top word on the bus and leaves the stack unchanged.

The top two entries are always driven on two dedicated operand outputs, so an ALU can read both inputs without any bus traffic. Asserting push and pop in the same cycle replaces the top entry, which is the usual write-back of a binary operation. The unit reports its depth, full and empty conditions, and two sticky error flags: one for writes that were refused and one for reads of an empty stack. The depth is a parameter. Four levels is the default, and the parameter accepts values from 2 to 256.

Top module: `lifo_stack_unit`

## Requirements
- R1: A synchronous reset, active high, sets the depth count to 0, sets the empty flag to 1, and clears the full flag, both error flags and both operand outputs to 0.
- R2: A push (push high, pop low) on a stack that is not full stores the bus word as the new top at the clock edge. The count rises by one and the previous top becomes the second entry.
- R3: A pop (pop high, push low) on a non-empty stack drives the top word onto the bus in that cycle. At the edge the top entry is removed, the count falls by one and the second entry becomes the top.
- R4: A peek (peek high, push low, pop low) drives the top word onto the bus and leaves the count and all entries unchanged.
- R5: Push and pop high together on a non-empty stack form a replace. The top entry is overwritten with the bus word and the count is unchanged. The old top stays readable on the A operand output for that whole cycle. On an empty stack the same pair of strobes acts as a plain push.
- R6: The A operand output equals the top entry when the count is at least 1 and reads 0 otherwise. The B operand output equals the second entry when the count is at least 2 and reads 0 otherwise.
- R7: The count output always equals the number of stored entries and never exceeds the depth. The full flag is 1 exactly when the count equals the depth. The empty flag is 1 exactly when the count is 0.
- R8: A push without pop on a full stack is ignored: the count and the entries are unchanged. It sets the overflow flag, which stays set until reset.
- R9: A pop or peek without push on an empty stack drives 0 onto the bus and leaves the count at 0. It sets the underflow flag, which stays set until reset.
- R10: The unit drives the bus only while pop or peek is high and push is low. At all other times it releases the bus, so a pushed word arrives in storage intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Store the bus word as the new top |
| pop_i | input | 1 | Read and remove the top word |
| peek_i | input | 1 | Read the top word without removing it |
| data_io | inout | DATA_W | Bidirectional CPU data bus |
| alu_a_o | output | DATA_W | Top entry, 0 when the stack is empty |
| alu_b_o | output | DATA_W | Second entry, 0 when fewer than two entries |
| count_o | output | $clog2(DEPTH+1) | Number of stored entries |
| full_o | output | 1 | Count equals DEPTH |
| empty_o | output | 1 | Count equals 0 |
| ovf_o | output | 1 | Sticky flag for a refused push |
| udf_o | output | 1 | Sticky flag for a read of an empty stack |

## Verification
The bench builds the unit with its default parameters: an 8-bit word and four levels. With only four levels, four pushes reach the full boundary, so one directed sequence covers the refused fifth push, B-operand masking at a count of one, and replace in the middle of the stack. Draining the same stack then covers the pop order, underflow on both pop and peek, and replace on an empty stack, all without a long run.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

   // Action applied to every storage entry in a cycle
   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2,
      STK_REPL = 2'd3
   } stk_op_e;

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
   import lifo_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             peek_i,
   output stk_op_e          op_o,
   output logic [CNT_W-1:0] count_o,
   output logic             full_o,
   output logic             empty_o,
   output logic             ovf_o,
   output logic             udf_o,
   output logic             drive_en_o
);

   logic [CNT_W-1:0] count_q;
   logic             ovf_q, udf_q;
   logic             is_full, is_empty;
   logic             only_push, only_read, both;
   logic             inc, dec;
   stk_op_e          op;

   assign is_full   = (count_q == CNT_W'(DEPTH));
   assign is_empty  = (count_q == '0);
   assign only_push = push_i & ~pop_i;
   assign only_read = (pop_i | peek_i) & ~push_i;
   assign both      = push_i & pop_i;

   always_comb begin
      op  = STK_HOLD;
      inc = 1'b0;
      dec = 1'b0;
      if (both) begin
         if (is_empty) begin
            op  = STK_PUSH;
            inc = 1'b1;
         end else begin
            op  = STK_REPL;
         end
      end else if (only_push && !is_full) begin
         op  = STK_PUSH;
         inc = 1'b1;
      end else if (pop_i && !push_i && !is_empty) begin
         op  = STK_POP;
         dec = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
         udf_q   <= 1'b0;
      end else begin
         if (inc)      count_q <= count_q + CNT_W'(1);
         else if (dec) count_q <= count_q - CNT_W'(1);
         if (only_push && is_full) ovf_q <= 1'b1;
         if (only_read && is_empty) udf_q <= 1'b1;
      end
   end

   assign op_o       = op;
   assign count_o    = count_q;
   assign full_o     = is_full;
   assign empty_o    = is_empty;
   assign ovf_o      = ovf_q;
   assign udf_o      = udf_q;
   assign drive_en_o = only_read;

endmodule

// File: rtl/lifo_cell.sv
module lifo_cell
   import lifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit IS_TOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  stk_op_e           op_i,
   input  logic [DATA_W-1:0] from_above_i,
   input  logic [DATA_W-1:0] from_below_i,
   output logic [DATA_W-1:0] q_o
);

   logic [DATA_W-1:0] q;

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         unique case (op_i)
            STK_PUSH: q <= from_above_i;
            STK_POP:  q <= from_below_i;
            STK_REPL: if (IS_TOP) q <= from_above_i;
            default:  q <= q;
         endcase
      end
   end

   assign q_o = q;

endmodule

// File: rtl/lifo_port.sv
module lifo_port #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 3
) (
   input  logic [DATA_W-1:0] top_i,
   input  logic [DATA_W-1:0] second_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [DATA_W-1:0] alu_a_o,
   output logic [DATA_W-1:0] alu_b_o
);

   logic have_one, have_two;

   assign have_one  = (count_i != '0);
   assign have_two  = (count_i > CNT_W'(1));
   assign alu_a_o   = have_one ? top_i : '0;
   assign alu_b_o   = have_two ? second_i : '0;
   assign rd_data_o = alu_a_o;

endmodule

// File: rtl/lifo_stack_unit.sv
module lifo_stack_unit
   import lifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic              peek_i,
   inout  wire  [DATA_W-1:0] data_io,
   output logic [DATA_W-1:0] alu_a_o,
   output logic [DATA_W-1:0] alu_b_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              full_o,
   output logic              empty_o,
   output logic              ovf_o,
   output logic              udf_o
);

   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("lifo_stack_unit: DEPTH must lie in 2..256");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("lifo_stack_unit: DATA_W must be positive");
   end

   stk_op_e           op;
   logic              drive_en;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] bus_in;
   logic [DATA_W-1:0] ent_q [DEPTH];

   assign bus_in  = data_io;
   assign data_io = drive_en ? rd_data : {DATA_W{1'bz}};

   lifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .push_i     (push_i),
      .pop_i      (pop_i),
      .peek_i     (peek_i),
      .op_o       (op),
      .count_o    (count_o),
      .full_o     (full_o),
      .empty_o    (empty_o),
      .ovf_o      (ovf_o),
      .udf_o      (udf_o),
      .drive_en_o (drive_en)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [DATA_W-1:0] above, below;
      if (i == 0) begin : g_top
         assign above = bus_in;
      end else begin : g_mid
         assign above = ent_q[i-1];
      end
      if (i == DEPTH - 1) begin : g_last
         assign below = '0;
      end else begin : g_inner
         assign below = ent_q[i+1];
      end
      lifo_cell #(.DATA_W(DATA_W), .IS_TOP(i == 0)) u_cell (
         .clk          (clk),
         .rst          (rst),
         .op_i         (op),
         .from_above_i (above),
         .from_below_i (below),
         .q_o          (ent_q[i])
      );
   end

   lifo_port #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_port (
      .top_i     (ent_q[0]),
      .second_i  (ent_q[1]),
      .count_i   (count_o),
      .rd_data_o (rd_data),
      .alu_a_o   (alu_a_o),
      .alu_b_o   (alu_b_o)
   );

endmodule

// File: rtl/lifo_stack_chk.sv
module lifo_stack_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              push_i,
   input logic              pop_i,
   input logic              peek_i,
   input logic [DATA_W-1:0] data_io,
   input logic [DATA_W-1:0] alu_a_o,
   input logic [DATA_W-1:0] alu_b_o,
   input logic [CNT_W-1:0]  count_o,
   input logic              full_o,
   input logic              empty_o,
   input logic              ovf_o,
   input logic              udf_o
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (count_o == '0) && !ovf_o && !udf_o);

   // R2
   push_grow_chk: assert property (@(posedge clk) disable iff (rst)
      (push_i && !pop_i && !full_o) |=>
         (count_o == $past(count_o) + CNT_W'(1)) && (alu_a_o == $past(data_io)));

   // R3
   pop_shrink_chk: assert property (@(posedge clk) disable iff (rst)
      (pop_i && !push_i && !empty_o) |=>
         (count_o == $past(count_o) - CNT_W'(1)));

   // R4
   peek_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (peek_i && !push_i && !pop_i) |=>
         $stable(count_o) && $stable(alu_a_o) && $stable(alu_b_o));

   // R5
   replace_chk: assert property (@(posedge clk) disable iff (rst)
      (push_i && pop_i && !empty_o) |=>
         $stable(count_o) && (alu_a_o == $past(data_io)));

   // R6
   empty_operands_chk: assert property (@(posedge clk) disable iff (rst)
      empty_o |-> (alu_a_o == '0) && (alu_b_o == '0));

   // R7
   count_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (count_o <= CNT_W'(DEPTH)) && !(full_o && empty_o));

   // R8
   overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (push_i && !pop_i && full_o) |=> $stable(count_o) && ovf_o);

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_o |=> ovf_o);

   // R9
   udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      udf_o |=> udf_o);

   // R9
   underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
      ((pop_i || peek_i) && !push_i && empty_o) |=> udf_o && (count_o == '0));

endmodule

bind lifo_stack_unit lifo_stack_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .push_i  (push_i),
   .pop_i   (pop_i),
   .peek_i  (peek_i),
   .data_io (data_io),
   .alu_a_o (alu_a_o),
   .alu_b_o (alu_b_o),
   .count_o (count_o),
   .full_o  (full_o),
   .empty_o (empty_o),
   .ovf_o   (ovf_o),
   .udf_o   (udf_o)
);

// File: tb/sim_lifo_stack_unit.sv
`timescale 1ns/1ps
module sim_lifo_stack_unit;

   localparam int DW = 8;
   localparam int DP = 4;
   localparam int CW = $clog2(DP + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          push = 1'b0, pop = 1'b0, peek = 1'b0;
   logic          tb_en = 1'b0;
   logic [DW-1:0] tb_val = '0;
   wire  [DW-1:0] bus;
   logic [DW-1:0] alu_a, alu_b;
   logic [CW-1:0] count;
   logic          full, empty, ovf, udf;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   assign bus = tb_en ? tb_val : {DW{1'bz}};

   always #2.5 clk = ~clk;

   lifo_stack_unit #(.DATA_W(DW), .DEPTH(DP)) u0 (
      .clk (clk), .rst (rst), .push_i (push), .pop_i (pop), .peek_i (peek),
      .data_io (bus), .alu_a_o (alu_a), .alu_b_o (alu_b), .count_o (count),
      .full_o (full), .empty_o (empty), .ovf_o (ovf), .udf_o (udf)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_state(input string req, input int c, input int a, input int b,
                              input int f, input int e, input int o, input int u);
      check({req, " count"}, int'(count), c);
      check({req, " alu_a"}, int'(alu_a), a);
      check({req, " alu_b"}, int'(alu_b), b);
      check({req, " full"},  int'(full), f);
      check({req, " empty"}, int'(empty), e);
      check({req, " ovf"},   int'(ovf), o);
      check({req, " udf"},   int'(udf), u);
   endtask

   // One bus cycle; rd is the bus and apre the A operand, both before the edge
   task automatic step(input logic p, input logic q, input logic k, input logic [DW-1:0] v,
                       output logic [DW-1:0] rd, output logic [DW-1:0] apre);
      @(negedge clk);
      push = p; pop = q; peek = k; tb_en = p; tb_val = v;
      #1;
      rd = bus; apre = alu_a;
      @(posedge clk);
      #1;
      push = 1'b0; pop = 1'b0; peek = 1'b0; tb_en = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk); rst = 1'b1;
      repeat (3) @(posedge clk);
      #1; rst = 1'b0;
      check_state("R1 reset", 0, 0, 0, 0, 1, 0, 0);
   endtask

   task automatic t_fill();
      logic [DW-1:0] rd, ap;
      step(1, 0, 0, 8'h11, rd, ap);
      check_state("R2 R6 push1", 1, 'h11, 0, 0, 0, 0, 0);
      step(1, 0, 0, 8'h22, rd, ap);
      check_state("R2 R10 push2", 2, 'h22, 'h11, 0, 0, 0, 0);
      step(1, 0, 0, 8'h33, rd, ap);
      check_state("R2 push3", 3, 'h33, 'h22, 0, 0, 0, 0);
      step(1, 0, 0, 8'h44, rd, ap);
      check_state("R7 full", 4, 'h44, 'h33, 1, 0, 0, 0);
   endtask

   task automatic t_overflow();
      logic [DW-1:0] rd, ap;
      step(1, 0, 0, 8'h55, rd, ap);
      check_state("R8 overflow", 4, 'h44, 'h33, 1, 0, 1, 0);
   endtask

   task automatic t_peek();
      logic [DW-1:0] rd, ap;
      step(0, 0, 1, 8'h00, rd, ap);
      check("R4 peek bus", int'(rd), 'h44);
      check_state("R4 peek", 4, 'h44, 'h33, 1, 0, 1, 0);
   endtask

   task automatic t_pop_replace();
      logic [DW-1:0] rd, ap;
      step(0, 1, 0, 8'h00, rd, ap);
      check("R3 pop bus", int'(rd), 'h44);
      check_state("R3 pop", 3, 'h33, 'h22, 0, 0, 1, 0);
      step(1, 1, 0, 8'h99, rd, ap);
      check("R5 old top", int'(ap), 'h33);
      check("R10 replace bus", int'(rd), 'h99);
      check_state("R5 replace", 3, 'h99, 'h22, 0, 0, 1, 0);
   endtask

   task automatic t_drain();
      logic [DW-1:0] rd, ap;
      step(0, 1, 0, 8'h00, rd, ap);
      check("R3 drain1 bus", int'(rd), 'h99);
      check_state("R3 drain1", 2, 'h22, 'h11, 0, 0, 1, 0);
      step(0, 1, 0, 8'h00, rd, ap);
      check("R3 drain2 bus", int'(rd), 'h22);
      check_state("R6 drain2", 1, 'h11, 0, 0, 0, 1, 0);
      step(0, 1, 0, 8'h00, rd, ap);
      check("R3 drain3 bus", int'(rd), 'h11);
      check_state("R7 empty", 0, 0, 0, 0, 1, 1, 0);
   endtask

   task automatic t_underflow();
      logic [DW-1:0] rd, ap;
      step(0, 1, 0, 8'h00, rd, ap);
      check("R9 pop empty bus", int'(rd), 0);
      check_state("R9 pop empty", 0, 0, 0, 0, 1, 1, 1);
      step(0, 0, 1, 8'h00, rd, ap);
      check("R9 peek empty bus", int'(rd), 0);
      check_state("R9 peek empty", 0, 0, 0, 0, 1, 1, 1);
      step(1, 1, 0, 8'h77, rd, ap);
      check_state("R5 replace empty", 1, 'h77, 0, 0, 0, 1, 1);
   endtask

   initial begin
      t_reset();
      t_fill();
      t_overflow();
      t_peek();
      t_pop_replace();
      t_drain();
      t_underflow();
      t_reset();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule